// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block turns one scalar operation whose operands are tagged as vectors into an ordered series of element operations for a downstream execution unit. For each element it works out the destination and source register numbers, whether the element runs normally, is zeroed or is skipped, and which element and sub-element is current. The program counter is held for as long as the series is running.

The vector length, the sub-vector group size and the saved loop offsets come from a separate state unit. Every offset change is written back to that unit. As a result, a loop that stops on an exception can later resume at the exact element and sub-element where it stopped. A predicate mask picks which element groups take part. Fail-first mode can end the loop early and report a shortened vector length.

Elements are handed over one at a time with a valid/ready handshake. The sequencer then waits for that element's response before it moves on, so elements retire strictly in index order.

Top module: `vseq_loop`

## Requirements
- R1: `pc_hold` is high from the cycle after an accepted `start` until the cycle in which `done` or `trap` pulses, where it is low. Outside a loop it is low.
- R2: The first element issued uses the index given by `dstoffs_in` and the sub-element given by `suboffs_in`, not zero.
- R3: A vector operand with base `b` uses register `(b + idx*S + sub) mod 2^REG_W`, where S is the sub-vector count. A scalar operand keeps `b` for every element.
- R4: In non-zeroing mode, an element whose effective predicate bit is 0 is not issued. The loop moves past it, and `offs_we` reports the advanced offsets.
- R5: In zeroing mode without fail-first, a masked-off element is issued with `el_zero`=1, once for each sub-element.
- R6: A response with `rsp_exc`=1 ends the loop with a one-cycle `trap` pulse and no `done`. The offsets are not advanced past that element, so the last values written name the faulting element and sub-element.
- R7: When the last element completes, `done` pulses with `done_vl` equal to VL, and offsets of zero are written with `offs_we`.
- R8: `subvl_in` encodes the group size as 00=1, 01=2, 10=3 and 11=4. Each element is issued once per sub-element, in ascending order, and all sub-elements share that element's single predicate bit.
- R9: In fail-first mode, a zero result (`rsp_zero`) or a floating-point negative-zero result (`rsp_negz`) on element i ends the loop. `done` then carries `done_vl`=i, zero offsets are written, and nothing further is issued. Without fail-first, zero results do not change the sequence.
- R10: In fail-first mode with zeroing, the first masked-off element ends the loop at once with `done_vl` equal to its index and is not issued. In fail-first mode without zeroing, masked-off elements are skipped and never tested.
- R11: The effective mask is `pmask` (forced to 0 when `pmask_x0`=1), complemented when `pinv`=1. Bit i belongs to element i, so `pmask_x0`=1 with `pinv`=1 enables every element.
- R12: While `el_valid` is high and `el_ready` is low, `el_valid` stays high and every `el_*` field holds its value.
- R13: When no operand is tagged as a vector, exactly one operation is issued and `done` returns VL unchanged. No offsets are written, and the predicate is ignored.
- R14: After reset the sequencer is idle: `pc_hold`, `el_valid`, `done`, `trap` and `offs_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a loop (sampled only when idle) |
| vl_in | input | OFF_W+1 | Vector length, 1..MAXVL |
| subvl_in | input | 2 | Sub-vector count minus one |
| srcoffs_in | input | OFF_W | Saved source element offset |
| dstoffs_in | input | OFF_W | Saved destination element offset |
| suboffs_in | input | 2 | Saved sub-element offset |
| rd_base | input | REG_W | Destination register number |
| rs1_base | input | REG_W | First source register number |
| rs2_base | input | REG_W | Second source register number |
| rd_vec | input | 1 | Destination is a vector |
| rs1_vec | input | 1 | First source is a vector |
| rs2_vec | input | 1 | Second source is a vector |
| pmask | input | MAXVL | Predicate mask word |
| pmask_x0 | input | 1 | Predicate taken from register 0 (mask reads as 0) |
| pinv | input | 1 | Complement the mask |
| pzero | input | 1 | Zeroing mode |
| pff | input | 1 | Fail-first mode |
| el_valid | output | 1 | Element operation offered |
| el_ready | input | 1 | Execution unit accepts the element |
| el_rd | output | REG_W | Element destination register |
| el_rs1 | output | REG_W | Element first source register |
| el_rs2 | output | REG_W | Element second source register |
| el_idx | output | OFF_W | Element index |
| el_sub | output | 2 | Sub-element index |
| el_zero | output | 1 | Write zero instead of a result |
| rsp_valid | input | 1 | Response for the outstanding element |
| rsp_zero | input | 1 | Result was zero |
| rsp_negz | input | 1 | Result was floating-point negative zero |
| rsp_exc | input | 1 | Element raised an exception |
| pc_hold | output | 1 | Program counter must not advance |
| done | output | 1 | Loop finished (one-cycle pulse) |
| done_vl | output | OFF_W+1 | Final vector length |
| trap | output | 1 | Loop stopped by an exception (one-cycle pulse) |
| offs_we | output | 1 | Offset write-back strobe |
| offs_src | output | OFF_W | Source offset written back |
| offs_dst | output | OFF_W | Destination offset written back |
| offs_sub | output | 2 | Sub-element offset written back |

## Verification
The assertions check several properties on every cycle:
- the handshake fields stay frozen while an element is stalled;
- `done` and `trap` never coincide, and `pc_hold` is released in the cycle either one pulses;
- a trap never writes offsets, and a finishing write is all zeros;
- a zeroed element is never offered in fail-first mode;
- the reported length never exceeds VL.

Only the bench scenarios can show the rest: the exact sequence of register numbers, skip and zero decisions across sub-element groups, resumption from saved offsets, the truncated length after a zero or negative-zero result, and the single-shot pass-through. For these, the bench compares every issued element and the final outcome with a reference model driven by random masks, modes and response patterns.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_EVAL  = 2'd1,
      S_ISSUE = 2'd2,
      S_WAIT  = 2'd3
   } vseq_state_e;

   // group size from its two-bit encoding (00 -> 1 ... 11 -> 4)
   function automatic logic [2:0] grp_count(input logic [1:0] enc);
      return {1'b0, enc} + 3'd1;
   endfunction
endpackage

// File: rtl/vseq_pred.sv
module vseq_pred #(
   parameter int MAXVL = 32,
   localparam int OFF_W = $clog2(MAXVL)
) (
   input  logic [MAXVL-1:0] mask,
   input  logic             use_x0,
   input  logic             inv,
   input  logic [OFF_W-1:0] idx,
   output logic             bit_o
);
   logic [MAXVL-1:0] raw;
   logic [MAXVL-1:0] eff;

   assign raw   = use_x0 ? '0 : mask;
   assign eff   = raw ^ {MAXVL{inv}};
   assign bit_o = eff[idx];
endmodule

// File: rtl/vseq_regmap.sv
module vseq_regmap #(
   parameter int REG_W = 7,
   parameter int OFF_W = 5,
   localparam int PW = OFF_W + 3,
   localparam int SW = ((REG_W > PW) ? REG_W : PW) + 1
) (
   input  logic [REG_W-1:0] base,
   input  logic             is_vec,
   input  logic [OFF_W-1:0] idx,
   input  logic [1:0]       sub,
   input  logic [2:0]       cnt,
   output logic [REG_W-1:0] reg_o
);
   logic [SW-1:0] lin;
   logic [SW-1:0] sum;

   assign lin   = SW'(idx) * SW'(cnt) + SW'(sub);
   assign sum   = SW'(base) + lin;
   assign reg_o = is_vec ? sum[REG_W-1:0] : base;
endmodule

// File: rtl/vseq_loop.sv
module vseq_loop
   import vseq_pkg::*;
#(
   parameter int REG_W = 7,
   parameter int MAXVL = 32,
   localparam int OFF_W = $clog2(MAXVL),
   localparam int VL_W  = OFF_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VL_W-1:0]  vl_in,
   input  logic [1:0]       subvl_in,
   input  logic [OFF_W-1:0] srcoffs_in,
   input  logic [OFF_W-1:0] dstoffs_in,
   input  logic [1:0]       suboffs_in,
   input  logic [REG_W-1:0] rd_base,
   input  logic [REG_W-1:0] rs1_base,
   input  logic [REG_W-1:0] rs2_base,
   input  logic             rd_vec,
   input  logic             rs1_vec,
   input  logic             rs2_vec,
   input  logic [MAXVL-1:0] pmask,
   input  logic             pmask_x0,
   input  logic             pinv,
   input  logic             pzero,
   input  logic             pff,
   output logic             el_valid,
   input  logic             el_ready,
   output logic [REG_W-1:0] el_rd,
   output logic [REG_W-1:0] el_rs1,
   output logic [REG_W-1:0] el_rs2,
   output logic [OFF_W-1:0] el_idx,
   output logic [1:0]       el_sub,
   output logic             el_zero,
   input  logic             rsp_valid,
   input  logic             rsp_zero,
   input  logic             rsp_negz,
   input  logic             rsp_exc,
   output logic             pc_hold,
   output logic             done,
   output logic [VL_W-1:0]  done_vl,
   output logic             trap,
   output logic             offs_we,
   output logic [OFF_W-1:0] offs_src,
   output logic [OFF_W-1:0] offs_dst,
   output logic [1:0]       offs_sub
);
   localparam int NOPS = 3;

   if (MAXVL < 2 || (MAXVL & (MAXVL - 1)) != 0) begin : g_bad_maxvl
      $error("vseq_loop: MAXVL must be a power of two of at least 2");
   end
   if (REG_W < 5) begin : g_bad_regw
      $error("vseq_loop: REG_W must be at least 5");
   end

   vseq_state_e      state;
   logic [VL_W-1:0]  vl_q;
   logic [2:0]       subn_q;
   logic [MAXVL-1:0] mask_q;
   logic             x0_q, inv_q, zer_q, ff_q, single_q, zel_q;
   logic [REG_W-1:0] base_q [NOPS];
   logic [NOPS-1:0]  vec_q;
   logic [OFF_W-1:0] dst_q, src_q;
   logic [1:0]       sub_q;
   logic             done_q, trap_q, owe_q;
   logic [VL_W-1:0]  done_vl_q;
   logic [OFF_W-1:0] osrc_q, odst_q;
   logic [1:0]       osub_q;

   logic             pbit;
   logic             last_el, last_sub, zero_res;
   logic [REG_W-1:0] map_reg [NOPS];

   vseq_pred #(.MAXVL(MAXVL)) u_pred (
      .mask   (mask_q),
      .use_x0 (x0_q),
      .inv    (inv_q),
      .idx    (dst_q),
      .bit_o  (pbit)
   );

   // operand 0 is the destination (destination index), 1 and 2 are sources
   for (genvar g = 0; g < NOPS; g++) begin : g_map
      vseq_regmap #(.REG_W(REG_W), .OFF_W(OFF_W)) u_map (
         .base   (base_q[g]),
         .is_vec (vec_q[g]),
         .idx    ((g == 0) ? dst_q : src_q),
         .sub    (sub_q),
         .cnt    (subn_q),
         .reg_o  (map_reg[g])
      );
   end

   assign last_el  = ({1'b0, dst_q} == (vl_q - VL_W'(1)));
   assign last_sub = ({1'b0, sub_q} == (subn_q - 3'd1));
   assign zero_res = rsp_zero | rsp_negz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         vl_q      <= '0;
         subn_q    <= 3'd1;
         mask_q    <= '0;
         x0_q      <= 1'b0;
         inv_q     <= 1'b0;
         zer_q     <= 1'b0;
         ff_q      <= 1'b0;
         single_q  <= 1'b0;
         zel_q     <= 1'b0;
         vec_q     <= '0;
         for (int i = 0; i < NOPS; i++) base_q[i] <= '0;
         dst_q     <= '0;
         src_q     <= '0;
         sub_q     <= '0;
         done_q    <= 1'b0;
         trap_q    <= 1'b0;
         owe_q     <= 1'b0;
         done_vl_q <= '0;
         osrc_q    <= '0;
         odst_q    <= '0;
         osub_q    <= '0;
      end else begin
         done_q <= 1'b0;
         trap_q <= 1'b0;
         owe_q  <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start) begin
                  vl_q      <= vl_in;
                  subn_q    <= grp_count(subvl_in);
                  mask_q    <= pmask;
                  x0_q      <= pmask_x0;
                  inv_q     <= pinv;
                  zer_q     <= pzero;
                  ff_q      <= pff;
                  base_q[0] <= rd_base;
                  base_q[1] <= rs1_base;
                  base_q[2] <= rs2_base;
                  vec_q     <= {rs2_vec, rs1_vec, rd_vec};
                  dst_q     <= dstoffs_in;
                  src_q     <= srcoffs_in;
                  sub_q     <= suboffs_in;
                  zel_q     <= 1'b0;
                  single_q  <= !(rd_vec | rs1_vec | rs2_vec);
                  state     <= (rd_vec | rs1_vec | rs2_vec) ? S_EVAL : S_ISSUE;
               end
            end
            S_EVAL: begin
               if (pbit) begin
                  zel_q <= 1'b0;
                  state <= S_ISSUE;
               end else if (!zer_q) begin
                  if (last_el) begin
                     done_q    <= 1'b1;
                     done_vl_q <= vl_q;
                     owe_q     <= 1'b1;
                     osrc_q    <= '0;
                     odst_q    <= '0;
                     osub_q    <= '0;
                     dst_q     <= '0;
                     src_q     <= '0;
                     sub_q     <= '0;
                     state     <= S_IDLE;
                  end else begin
                     dst_q  <= dst_q + 1'b1;
                     src_q  <= src_q + 1'b1;
                     sub_q  <= '0;
                     owe_q  <= 1'b1;
                     odst_q <= dst_q + 1'b1;
                     osrc_q <= src_q + 1'b1;
                     osub_q <= '0;
                  end
               end else if (ff_q) begin
                  done_q    <= 1'b1;
                  done_vl_q <= {1'b0, dst_q};
                  owe_q     <= 1'b1;
                  osrc_q    <= '0;
                  odst_q    <= '0;
                  osub_q    <= '0;
                  dst_q     <= '0;
                  src_q     <= '0;
                  sub_q     <= '0;
                  state     <= S_IDLE;
               end else begin
                  zel_q <= 1'b1;
                  state <= S_ISSUE;
               end
            end
            S_ISSUE: begin
               if (el_ready) state <= S_WAIT;
            end
            S_WAIT: begin
               if (rsp_valid) begin
                  if (rsp_exc) begin
                     trap_q <= 1'b1;
                     state  <= S_IDLE;
                  end else if (single_q) begin
                     done_q    <= 1'b1;
                     done_vl_q <= vl_q;
                     state     <= S_IDLE;
                  end else if ((ff_q && !zel_q && zero_res) || (last_sub && last_el)) begin
                     done_q    <= 1'b1;
                     done_vl_q <= (ff_q && !zel_q && zero_res) ? {1'b0, dst_q} : vl_q;
                     owe_q     <= 1'b1;
                     osrc_q    <= '0;
                     odst_q    <= '0;
                     osub_q    <= '0;
                     dst_q     <= '0;
                     src_q     <= '0;
                     sub_q     <= '0;
                     state     <= S_IDLE;
                  end else if (!last_sub) begin
                     sub_q  <= sub_q + 1'b1;
                     owe_q  <= 1'b1;
                     odst_q <= dst_q;
                     osrc_q <= src_q;
                     osub_q <= sub_q + 1'b1;
                     state  <= S_ISSUE;
                  end else begin
                     dst_q  <= dst_q + 1'b1;
                     src_q  <= src_q + 1'b1;
                     sub_q  <= '0;
                     owe_q  <= 1'b1;
                     odst_q <= dst_q + 1'b1;
                     osrc_q <= src_q + 1'b1;
                     osub_q <= '0;
                     state  <= S_EVAL;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign el_valid = (state == S_ISSUE);
   assign el_rd    = map_reg[0];
   assign el_rs1   = map_reg[1];
   assign el_rs2   = map_reg[2];
   assign el_idx   = dst_q;
   assign el_sub   = sub_q;
   assign el_zero  = zel_q;
   assign pc_hold  = (state != S_IDLE);
   assign done     = done_q;
   assign done_vl  = done_vl_q;
   assign trap     = trap_q;
   assign offs_we  = owe_q;
   assign offs_src = osrc_q;
   assign offs_dst = odst_q;
   assign offs_sub = osub_q;
endmodule

// File: rtl/vseq_loop_chk.sv
module vseq_loop_chk #(
   parameter int REG_W = 7,
   parameter int MAXVL = 32,
   localparam int OFF_W = $clog2(MAXVL),
   localparam int VL_W  = OFF_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             el_valid,
   input logic             el_ready,
   input logic [REG_W-1:0] el_rd,
   input logic [REG_W-1:0] el_rs1,
   input logic [REG_W-1:0] el_rs2,
   input logic [OFF_W-1:0] el_idx,
   input logic [1:0]       el_sub,
   input logic             el_zero,
   input logic             pc_hold,
   input logic             done,
   input logic [VL_W-1:0]  done_vl,
   input logic             trap,
   input logic             offs_we,
   input logic [OFF_W-1:0] offs_src,
   input logic [OFF_W-1:0] offs_dst,
   input logic [1:0]       offs_sub,
   input logic             ff_q,
   input logic [VL_W-1:0]  vl_q
);
   p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (el_valid && !el_ready) |=> (el_valid && $stable(el_rd) && $stable(el_rs1)
         && $stable(el_rs2) && $stable(el_idx) && $stable(el_sub) && $stable(el_zero)));

   p_end_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && trap));

   p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done || trap) |-> !pc_hold);

   p_issue_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      el_valid |-> pc_hold);

   p_hold_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pc_hold) |-> $past(start));

   p_trap_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> !offs_we);

   p_finish_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && offs_we) |-> (offs_src == '0 && offs_dst == '0 && offs_sub == '0));

   p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_vl <= vl_q));

   p_no_zero_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
      el_valid |-> !(el_zero && ff_q));
endmodule

bind vseq_loop vseq_loop_chk #(.REG_W(REG_W), .MAXVL(MAXVL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .el_valid (el_valid),
   .el_ready (el_ready),
   .el_rd    (el_rd),
   .el_rs1   (el_rs1),
   .el_rs2   (el_rs2),
   .el_idx   (el_idx),
   .el_sub   (el_sub),
   .el_zero  (el_zero),
   .pc_hold  (pc_hold),
   .done     (done),
   .done_vl  (done_vl),
   .trap     (trap),
   .offs_we  (offs_we),
   .offs_src (offs_src),
   .offs_dst (offs_dst),
   .offs_sub (offs_sub),
   .ff_q     (ff_q),
   .vl_q     (vl_q)
);

// File: tb/tb_vseq_loop.sv
module tb_vseq_loop;
   localparam int REG_W = 7;
   localparam int MAXVL = 32;
   localparam int OFF_W = 5;
   localparam int VL_W  = 6;

   logic             clk, rst_n, start;
   logic [VL_W-1:0]  vl_in;
   logic [1:0]       subvl_in, suboffs_in;
   logic [OFF_W-1:0] srcoffs_in, dstoffs_in;
   logic [REG_W-1:0] rd_base, rs1_base, rs2_base;
   logic             rd_vec, rs1_vec, rs2_vec;
   logic [MAXVL-1:0] pmask;
   logic             pmask_x0, pinv, pzero, pff;
   logic             el_valid, el_ready;
   logic [REG_W-1:0] el_rd, el_rs1, el_rs2;
   logic [OFF_W-1:0] el_idx;
   logic [1:0]       el_sub;
   logic             el_zero;
   logic             rsp_valid, rsp_zero, rsp_negz, rsp_exc;
   logic             pc_hold, done, trap, offs_we;
   logic [VL_W-1:0]  done_vl;
   logic [OFF_W-1:0] offs_src, offs_dst;
   logic [1:0]       offs_sub;

   vseq_loop #(.REG_W(REG_W), .MAXVL(MAXVL)) dut (.*);

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   // case configuration
   int c_vl, c_senc, c_off, c_soff, c_x0, c_inv, c_zer, c_ff, zk, ek, negz;
   bit [31:0] c_mask;
   int c_vec [3];
   int c_base [3];

   // expected results
   int e_idx [160];
   int e_sub [160];
   int e_z   [160];
   int e_n, e_end, e_vl, e_odst, e_osub;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic push(input int i, input int s, input int z);
      e_idx[e_n] = i; e_sub[e_n] = s; e_z[e_n] = z; e_n++;
   endtask

   function automatic int exp_reg(input int op, input int i, input int s);
      if (c_vec[op] == 0) return c_base[op];
      return (c_base[op] + i * (c_senc + 1) + s) % (1 << REG_W);
   endfunction

   task automatic ref_model();
      bit [31:0] eff;
      int sn, i, s, k;
      bit b, fin;
      eff = (c_x0 != 0 ? 32'h0 : c_mask) ^ (c_inv != 0 ? 32'hFFFF_FFFF : 32'h0);
      sn = c_senc + 1;
      e_n = 0;
      if (c_vec[0] == 0 && c_vec[1] == 0 && c_vec[2] == 0) begin
         push(0, 0, 0);
         e_end = (ek == 0) ? 2 : 1;
         e_vl = c_vl; e_odst = 0; e_osub = 0;
         return;
      end
      i = c_off; s = c_soff; k = 0; fin = 0;
      while (!fin) begin
         b = eff[i];
         if (!b && c_zer == 0) begin
            if (i == c_vl - 1) begin fin = 1; e_end = 1; e_vl = c_vl; e_odst = 0; e_osub = 0; end
            else begin i++; s = 0; end
         end else if (!b && c_ff != 0) begin
            fin = 1; e_end = 1; e_vl = i; e_odst = 0; e_osub = 0;
         end else begin
            while (s < sn && !fin) begin
               push(i, s, b ? 0 : 1);
               if (k == ek) begin fin = 1; e_end = 2; e_odst = i; e_osub = s; end
               else if (c_ff != 0 && b && k == zk) begin fin = 1; e_end = 1; e_vl = i; e_odst = 0; e_osub = 0; end
               else s++;
               k++;
            end
            if (!fin) begin
               if (i == c_vl - 1) begin fin = 1; e_end = 1; e_vl = c_vl; e_odst = 0; e_osub = 0; end
               else begin i++; s = 0; end
            end
         end
      end
   endtask

   task automatic run_case(input string req);
      int k, cur, phase, cyc, got_end, g_vl, t_odst, t_osub, t_osrc;
      bit hold_bad, owe_seen, scalar;
      ref_model();
      scalar = (c_vec[0] == 0 && c_vec[1] == 0 && c_vec[2] == 0);
      vl_in = VL_W'(c_vl); subvl_in = 2'(c_senc);
      dstoffs_in = OFF_W'(c_off); srcoffs_in = OFF_W'(c_off); suboffs_in = 2'(c_soff);
      rd_base = REG_W'(c_base[0]); rs1_base = REG_W'(c_base[1]); rs2_base = REG_W'(c_base[2]);
      rd_vec = c_vec[0] != 0; rs1_vec = c_vec[1] != 0; rs2_vec = c_vec[2] != 0;
      pmask = c_mask; pmask_x0 = c_x0 != 0; pinv = c_inv != 0; pzero = c_zer != 0; pff = c_ff != 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      hold_bad = !pc_hold;
      phase = 0; k = 0; cur = 0; cyc = 0; got_end = 0; g_vl = -1; owe_seen = 0;
      t_odst = c_off; t_osrc = c_off; t_osub = c_soff;
      while (got_end == 0 && cyc < 3000) begin
         if (phase == 2) begin
            rsp_valid = 1'b0; rsp_zero = 1'b0; rsp_negz = 1'b0; rsp_exc = 1'b0; phase = 0;
         end
         if (offs_we) begin
            owe_seen = 1; t_odst = int'(offs_dst); t_osrc = int'(offs_src); t_osub = int'(offs_sub);
         end
         if (done || trap) begin
            got_end = done ? 1 : 2; g_vl = int'(done_vl);
            if (pc_hold) hold_bad = 1;
         end else begin
            if (!pc_hold) hold_bad = 1;
            if (phase == 1) begin
               el_ready = 1'b0; rsp_valid = 1'b1;
               rsp_exc  = (cur == ek);
               rsp_zero = (cur == zk) && negz == 0;
               rsp_negz = (cur == zk) && negz != 0;
               phase = 2;
            end else if (el_valid && ($urandom % 4 != 0)) begin
               if (k < e_n) begin
                  // R2 R3 R5 R8: element order, registers and zeroing
                  chk("R3", "el_rd", el_rd, exp_reg(0, e_idx[k], e_sub[k]));
                  chk("R3", "el_rs1", el_rs1, exp_reg(1, e_idx[k], e_sub[k]));
                  chk("R3", "el_rs2", el_rs2, exp_reg(2, e_idx[k], e_sub[k]));
                  chk("R2", "el_idx", el_idx, e_idx[k]);
                  chk("R8", "el_sub", el_sub, e_sub[k]);
                  chk("R5", "el_zero", el_zero, e_z[k]);
               end else begin
                  chk(req, "extra issue", k, e_n);
               end
               el_ready = 1'b1; cur = k; k++; phase = 1;
            end
            @(negedge clk); cyc++;
         end
      end
      el_ready = 1'b0;
      if (got_end == 0) begin
         n_bad++; n_cmp++;
         $display("FAIL %s watchdog: got %0d expected %0d", req, 0, e_end);
      end
      chk(req, "outcome", got_end, e_end);
      if (e_end == 1) chk(req, "done_vl", g_vl, e_vl);
      chk(req, "issue count", k, e_n);
      chk(req, "offs_dst", t_odst, e_odst);
      chk(req, "offs_src", t_osrc, e_odst);
      chk(req, "offs_sub", t_osub, e_osub);
      chk("R1", "pc_hold", hold_bad, 0);
      if (scalar) chk("R13", "offs_we seen", owe_seen, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic base_cfg();
      c_vl = 4; c_senc = 0; c_off = 0; c_soff = 0; c_mask = 32'h0;
      c_x0 = 1; c_inv = 1; c_zer = 0; c_ff = 0; zk = -1; ek = -1; negz = 0;
      c_vec[0] = 1; c_vec[1] = 1; c_vec[2] = 0;
      c_base[0] = 8; c_base[1] = 40; c_base[2] = 5;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++; n_cmp++;
      $display("FAIL global watchdog: got %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; start = 1'b0; el_ready = 1'b0;
      rsp_valid = 1'b0; rsp_zero = 1'b0; rsp_negz = 1'b0; rsp_exc = 1'b0;
      base_cfg();
      vl_in = '0; subvl_in = '0; srcoffs_in = '0; dstoffs_in = '0; suboffs_in = '0;
      rd_base = '0; rs1_base = '0; rs2_base = '0; rd_vec = 0; rs1_vec = 0; rs2_vec = 0;
      pmask = '0; pmask_x0 = 0; pinv = 0; pzero = 0; pff = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R14 reset state
      chk("R14", "pc_hold", pc_hold, 0);
      chk("R14", "el_valid", el_valid, 0);
      chk("R14", "done", done, 0);
      chk("R14", "trap", trap, 0);
      chk("R14", "offs_we", offs_we, 0);

      // R7 R11: plain loop, all-ones mask from register 0 inverted
      base_cfg(); run_case("R7");
      // R4: non-zeroing skips
      base_cfg(); c_x0 = 0; c_inv = 0; c_mask = 32'b1010_0110; c_vl = 8; run_case("R4");
      // R11: inverted explicit mask
      base_cfg(); c_x0 = 0; c_inv = 1; c_mask = 32'b0101; c_vl = 6; run_case("R11");
      // R5: zeroing issues masked elements with zero flag
      base_cfg(); c_x0 = 0; c_inv = 0; c_mask = 32'b1001; c_zer = 1; c_vl = 5; run_case("R5");
      // R8: group of three, shared predicate bit
      base_cfg(); c_senc = 2; c_x0 = 0; c_inv = 0; c_mask = 32'b1101; c_zer = 1; run_case("R8");
      // R2: resume from saved element and sub-element
      base_cfg(); c_senc = 3; c_off = 2; c_soff = 1; c_vl = 5; run_case("R2");
      // R9: zero result truncates
      base_cfg(); c_ff = 1; c_vl = 8; zk = 3; run_case("R9");
      // R9: negative zero truncates
      base_cfg(); c_ff = 1; c_vl = 8; zk = 5; negz = 1; run_case("R9");
      // R9: zero ignored without fail-first
      base_cfg(); c_vl = 6; zk = 2; run_case("R9");
      // R10: fail-first zeroing stops at first masked element
      base_cfg(); c_ff = 1; c_zer = 1; c_x0 = 0; c_inv = 0; c_mask = 32'b0111; c_vl = 7; run_case("R10");
      // R10: fail-first non-zeroing skips without testing
      base_cfg(); c_ff = 1; c_x0 = 0; c_inv = 0; c_mask = 32'b1011; c_vl = 5; run_case("R10");
      // R6: exception mid-group
      base_cfg(); c_senc = 1; c_vl = 6; ek = 5; run_case("R6");
      // R6 then resume at the faulting position
      base_cfg(); c_senc = 1; c_vl = 6; c_off = 2; c_soff = 1; run_case("R6");
      // R13: all scalar pass-through ignores predicate
      base_cfg(); c_vec[0] = 0; c_vec[1] = 0; c_x0 = 0; c_inv = 0; c_mask = 0; c_zer = 1; c_vl = 9; run_case("R13");
      base_cfg(); c_vec[0] = 0; c_vec[1] = 0; ek = 0; run_case("R13");
      // R3: register wrap
      base_cfg(); c_base[0] = 126; c_base[2] = 100; c_vec[2] = 1; c_senc = 3; c_vl = 3; run_case("R3");
      // R12: handshake stalls occur throughout; full-length loop
      base_cfg(); c_vl = MAXVL; run_case("R12");

      // constrained random
      for (int n = 0; n < 80; n++) begin
         c_vl = 1 + int'($urandom % 12);
         c_senc = int'($urandom % 4);
         c_off = int'($urandom % c_vl);
         c_soff = int'($urandom % (c_senc + 1));
         c_mask = $urandom;
         c_x0 = ($urandom % 6 == 0) ? 1 : 0;
         c_inv = int'($urandom % 2);
         c_zer = int'($urandom % 2);
         c_ff = int'($urandom % 3 == 0);
         for (int o = 0; o < 3; o++) begin
            c_vec[o] = int'($urandom % 3 != 0);
            c_base[o] = int'($urandom % 128);
         end
         if (c_vec[0] == 0 && c_vec[1] == 0 && c_vec[2] == 0) begin c_off = 0; c_soff = 0; end
         zk = ($urandom % 2 == 0) ? int'($urandom % 16) : -1;
         ek = ($urandom % 4 == 0) ? int'($urandom % 20) : -1;
         negz = int'($urandom % 2);
         run_case("R7");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule